// File: doc/BRIEF.md
# Receive Timeout Interrupt Generator

This block produces the receive-timeout interrupt for a UART receiver that buffers characters in a FIFO. A down-counter is loaded with a 16-bit limit and steps once per character-time tick from the baud generator. When the count runs out, the interrupt line is raised. The line is a level. It stays high until software reads the interrupt identification register.

Two timeout modes are available, chosen by bit 6 of the feature register.
- **Standard mode** (bit 6 = 0): the counter only moves while the FIFO holds data, so the interrupt reports characters that are left waiting.
- **Periodic mode** (bit 6 = 1): the counter runs on every tick and fires at each expiry, even with an empty FIFO.

After an expiry the counter reloads itself, so a cleared interrupt comes back one full period later if its condition still holds. Reads of the receive data, line status and modem status registers reach this block but have no effect on it.

The interrupt control is a two-state machine:
- **QUIET**: the line is low.
- **PENDING**: the line is high.

There are two transitions:
- **QUIET → PENDING** on a count expiry (`fire`).
- **PENDING → QUIET** on an identification read in a cycle without an expiry (`ack`).

An expiry in the same cycle as the read keeps the machine in PENDING.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset the interrupt is low, the limit is 0 and the mode is standard. With these defaults, ticks never raise the interrupt.
- R2: The limit L is `{high byte written at address 1, low byte written at address 0}`. After the last reload, the interrupt rises on the clock edge that ends the L-th cycle in which `char_tick` is high and the counter is running. After L-1 such cycles it is still low.
- R3: The counter reloads to L on any of these events: a received-character pulse, a write to either limit address, or a write to address 2 that changes bit 6. The count then starts over.
- R4: While L is 0 the counter holds and the interrupt is never raised.
- R5: In standard mode (address 2 bit 6 = 0) the counter counts only while `fifo_level` is nonzero. While `fifo_level` is zero it holds its value without reloading.
- R6: In periodic mode (address 2 bit 6 = 1) the counter runs whatever the FIFO level. It raises the interrupt at every expiry, with L ticks between expiries.
- R7: A read of address 3 (identification) clears the interrupt on the following edge. If an expiry happens in the same cycle, the interrupt stays high.
- R8: Reads of addresses 4 (receive data), 5 (line status) and 6 (modem status) neither set nor clear the interrupt, and they do not disturb the count.
- R9: Once raised, the interrupt stays high, with or without ticks, until the identification read.
- R10: Switching from periodic to standard mode with an empty FIFO and the interrupt cleared leaves the interrupt low on later ticks.
- R11: In standard mode, after a clear with data still in the FIFO, the interrupt rises again after L further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_tick | input | 1 | One-cycle pulse per character time |
| rx_char | input | 1 | One-cycle pulse per received character |
| fifo_level | input | LVL_W (6) | Receive FIFO occupancy |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address for the read or write |
| reg_wdata | input | HALF_W (8) | Register write data |
| irq_out | output | 1 | Receive-timeout interrupt level |

## Verification
Every result of this block is due exactly one clock edge after the cycle that causes it:
- The interrupt rises on the edge that ends the L-th running tick cycle.
- It falls on the edge that ends the identification read.
- A reload takes effect on the edge that ends the write or character cycle.

The bench drives each stimulus on a falling edge and holds it for whole cycles. It samples `irq_out` on the falling edge after the last stimulus cycle. It checks both the L-1 point (still low) and the L point (high), so an off-by-one in the count is caught. The limit is swept from 1 to 10 in both modes, with the expected expiry point worked out from L alone.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    // Register map of the block (address width is fixed by the map)
    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] A_LIM_LO = 3'd0;
    localparam logic [REG_AW-1:0] A_LIM_HI = 3'd1;
    localparam logic [REG_AW-1:0] A_FEAT   = 3'd2;
    localparam logic [REG_AW-1:0] A_IDENT  = 3'd3;
    localparam logic [REG_AW-1:0] A_RXDATA = 3'd4;
    localparam logic [REG_AW-1:0] A_LINE   = 3'd5;
    localparam logic [REG_AW-1:0] A_MODEM  = 3'd6;

    // Position of the periodic-mode select inside the feature register
    localparam int unsigned PERIODIC_BIT = 6;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_PEND  = 1'b1
    } irq_state_t;

endpackage

// File: rtl/rxto_regs.sv
module rxto_regs
    import rxto_pkg::*;
#(
    parameter int unsigned HALF_W = 8,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic [CNT_W-1:0]  lim_next,
    output logic              periodic,
    output logic              cfg_evt
);

    logic [HALF_W-1:0] lo_q, lo_d;
    logic [HALF_W-1:0] hi_q, hi_d;
    logic              mode_q, mode_d;
    logic              lim_wr, mode_flip;

    always_comb begin
        lo_d      = lo_q;
        hi_d      = hi_q;
        mode_d    = mode_q;
        lim_wr    = 1'b0;
        mode_flip = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                A_LIM_LO: begin
                    lo_d   = wr_data;
                    lim_wr = 1'b1;
                end
                A_LIM_HI: begin
                    hi_d   = wr_data;
                    lim_wr = 1'b1;
                end
                A_FEAT: begin
                    mode_d    = wr_data[PERIODIC_BIT];
                    mode_flip = (wr_data[PERIODIC_BIT] != mode_q);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            mode_q <= 1'b0;
        end else begin
            lo_q   <= lo_d;
            hi_q   <= hi_d;
            mode_q <= mode_d;
        end
    end

    // The value the counter should hold after this cycle's write
    assign lim_next = {hi_d, lo_d};
    assign periodic = mode_q;
    assign cfg_evt  = lim_wr | mode_flip;

endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_tick,
    input  logic             rx_char,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [CNT_W-1:0] lim_next,
    input  logic             periodic,
    input  logic             cfg_evt,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic             reload;
    logic             run;
    logic             last;

    // A zero limit keeps the counter parked at its reload value
    assign reload = rx_char | cfg_evt | (lim_next == '0);
    assign run    = periodic | (fifo_level != '0);
    assign last   = (cnt_q <= CNT_W'(1));
    assign expire = char_tick & run & ~reload & last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= lim_next;
        end else if (char_tick && run) begin
            cnt_q <= last ? lim_next : cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/rxto_irq_fsm.sv
module rxto_irq_fsm
    import rxto_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    output logic irq
);

    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (expire)          state_d = ST_PEND;   // fire
            ST_PEND:  if (clr && !expire)  state_d = ST_QUIET;  // ack
            default:                       state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == ST_PEND);
    end

endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rxto_pkg::*;
#(
    parameter int unsigned HALF_W = 8,
    parameter int unsigned LVL_W  = 6,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_tick,
    input  logic              rx_char,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic              irq_out
);

    logic [CNT_W-1:0] lim_next;
    logic             periodic;
    logic             cfg_evt;
    logic             expire;
    logic             clr;

    // Only the identification read acts here; other reads are ignored
    assign clr = reg_rd & (reg_addr == A_IDENT);

    rxto_regs #(.HALF_W(HALF_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .lim_next (lim_next),
        .periodic (periodic),
        .cfg_evt  (cfg_evt)
    );

    rxto_counter #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_tick  (char_tick),
        .rx_char    (rx_char),
        .fifo_level (fifo_level),
        .lim_next   (lim_next),
        .periodic   (periodic),
        .cfg_evt    (cfg_evt),
        .expire     (expire)
    );

    rxto_irq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .clr    (clr),
        .irq    (irq_out)
    );

endmodule

// File: rtl/rxto_checker.sv
module rxto_checker #(
    parameter int unsigned LVL_W = 6,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_out,
    input logic             expire,
    input logic             clr,
    input logic             periodic,
    input logic [LVL_W-1:0] fifo_level,
    input logic [CNT_W-1:0] lim_next
);

    // R2 / R6: an expiry raises the line on the next edge
    a_r2_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq_out);

    // R7: identification read without a coincident expiry clears
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !expire) |=> !irq_out);

    // R8: nothing but an expiry may raise the line
    a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && !expire) |=> !irq_out);

    // R9: the line holds until the identification read
    a_r9_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !clr) |=> irq_out);

    // R4: a zero limit never expires
    a_r4_zero_limit_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_next == '0) |-> !expire);

    // R5: standard mode with an empty FIFO never expires
    a_r5_std_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && fifo_level == '0) |-> !expire);

endmodule

bind rx_idle_timeout rxto_checker #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_out    (irq_out),
    .expire     (expire),
    .clr        (clr),
    .periodic   (periodic),
    .fifo_level (fifo_level),
    .lim_next   (lim_next)
);

// File: tb/rx_idle_timeout_test.sv
`timescale 1ns/1ps
module rx_idle_timeout_test;

    localparam logic [2:0] AD_LO = 3'd0, AD_HI = 3'd1, AD_FEAT = 3'd2, AD_IDENT = 3'd3;
    localparam logic [2:0] AD_RX = 3'd4, AD_LSR = 3'd5, AD_MSR = 3'd6;
    localparam logic [7:0] MODE_PER = 8'h40, MODE_STD = 8'h00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_tick = 1'b0;
    logic       rx_char = 1'b0;
    logic [5:0] fifo_level = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_idle_timeout uut (
        .clk(clk), .rst_n(rst_n), .char_tick(char_tick), .rx_char(rx_char),
        .fifo_level(fifo_level), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_out(irq_out)
    );

    task automatic check(input logic exp, input string tag);
        n_chk++;
        if (irq_out !== exp) begin
            n_bad++;
            $display("FAIL %s: irq_out=%b expected=%b", tag, irq_out, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic rxc();
        @(negedge clk); rx_char = 1'b1;
        @(negedge clk); rx_char = 1'b0;
    endtask

    task automatic tick(input int n);
        if (n > 0) begin
            @(negedge clk); char_tick = 1'b1;
            repeat (n) @(negedge clk);
            char_tick = 1'b0;
        end
    endtask

    task automatic setup(input int lim, input logic [7:0] mode);
        wr(AD_LO, 8'(lim));
        wr(AD_HI, 8'(lim >> 8));
        wr(AD_FEAT, mode);
        rd(AD_IDENT);
        rxc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1 reset level");
        fifo_level = 6'd5;
        tick(20);
        check(1'b0, "R1 default limit zero stays quiet");

        // R2 / R6 / R11 sweep of limit and mode
        for (int m = 0; m < 2; m++) begin
            for (int lim = 1; lim <= 10; lim++) begin
                fifo_level = (m == 0) ? 6'd3 : 6'd0;
                setup(lim, (m == 0) ? MODE_STD : MODE_PER);
                tick(lim - 1);
                check(1'b0, "R2 low after L-1 ticks");
                tick(1);
                check(1'b1, (m == 0) ? "R2 std expiry at L" : "R6 periodic expiry at L");
                rd(AD_LSR);
                check(1'b1, "R8 line status read keeps level");
                rd(AD_IDENT);
                check(1'b0, "R7 identification read clears");
                tick(lim - 1);
                check(1'b0, "R11 low before second expiry");
                tick(1);
                check(1'b1, (m == 0) ? "R11 std refire with data" : "R6 periodic refire");
                rd(AD_IDENT);
            end
        end

        // R4: zero limit in periodic mode
        fifo_level = 6'd0;
        setup(0, MODE_PER);
        tick(30);
        check(1'b0, "R4 zero limit never fires");

        // R5: standard mode, empty FIFO holds, count resumes
        wr(AD_FEAT, MODE_STD);
        setup(5, MODE_STD);
        tick(20);
        check(1'b0, "R5 empty FIFO no count");
        fifo_level = 6'd2;
        tick(4);
        check(1'b0, "R5 low after 4 with data");
        tick(1);
        check(1'b1, "R5 fires after 5 with data");
        rd(AD_IDENT);
        setup(6, MODE_STD);
        fifo_level = 6'd1;
        tick(3);
        fifo_level = 6'd0;
        tick(10);
        fifo_level = 6'd1;
        tick(2);
        check(1'b0, "R5 held count not reloaded yet low");
        tick(1);
        check(1'b1, "R5 held count resumes to expiry");
        rd(AD_IDENT);

        // R3: reload events restart the count
        setup(8, MODE_STD);
        tick(5); rxc(); tick(7);
        check(1'b0, "R3 char reload low at 7");
        tick(1);
        check(1'b1, "R3 char reload fires at 8");
        rd(AD_IDENT);
        tick(5); wr(AD_LO, 8'd8); tick(7);
        check(1'b0, "R3 limit write reload low at 7");
        tick(1);
        check(1'b1, "R3 limit write reload fires at 8");
        rd(AD_IDENT);
        tick(5); wr(AD_FEAT, MODE_PER); tick(7);
        check(1'b0, "R3 mode change reload low at 7");
        tick(1);
        check(1'b1, "R3 mode change reload fires at 8");

        // R9: level holds without clear
        repeat (50) @(negedge clk);
        check(1'b1, "R9 level holds idle");
        tick(20);
        check(1'b1, "R9 level holds with ticks");
        rd(AD_RX); rd(AD_MSR);
        check(1'b1, "R8 data and modem reads keep level");
        rd(AD_IDENT);
        check(1'b0, "R7 clear after hold");

        // R8: other reads neither set nor disturb the count
        fifo_level = 6'd0;
        setup(4, MODE_PER);
        tick(2);
        rd(AD_RX); rd(AD_LSR); rd(AD_MSR);
        check(1'b0, "R8 reads do not set");
        tick(1);
        check(1'b0, "R8 count undisturbed low at 3");
        tick(1);
        check(1'b1, "R8 count undisturbed fires at 4");

        // R7: expiry coinciding with identification read keeps level
        setup(1, MODE_PER);
        tick(1);
        check(1'b1, "R7 L=1 fires");
        @(negedge clk); reg_rd = 1'b1; reg_addr = AD_IDENT; char_tick = 1'b1;
        @(negedge clk); reg_rd = 1'b0; char_tick = 1'b0;
        check(1'b1, "R7 coincident expiry wins");
        rd(AD_IDENT);
        check(1'b0, "R7 plain clear");

        // R10: periodic -> standard with empty FIFO stays low
        setup(3, MODE_PER);
        tick(3);
        check(1'b1, "R10 periodic fires before switch");
        rd(AD_IDENT);
        wr(AD_FEAT, MODE_STD);
        tick(20);
        check(1'b0, "R10 standard empty stays low");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: irq_out=%b expected=finish", irq_out);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule